// File: doc/BRIEF.md
# Paged Address Translator with Boot ROM Overlay

This block sits between a processor with a 16-bit address bus and a 64 KB dynamic RAM array made of four 16 KB banks. The logical space is cut into eight 8 KB pages. A small table maps each logical page to a physical 8 KB frame. The upper two bits of the 3-bit frame number pick one of the four banks through a one-hot select. The lowest frame bit becomes physical address bit 13 and picks the half of that bank. Software rewrites any table entry through a write port. Reset loads the identity mapping.

At power-up a slow boot ROM overlays the lowest page for reads. While the overlay is armed, a read from logical page 0 goes to the ROM and not to RAM, and the block raises a wait request for a fixed number of extra cycles to cover the ROM's longer access time. Writes always go to RAM. Software disarms the overlay with a single pulse. It stays disarmed until the next reset.

Each access is presented with a one-cycle start pulse. The translated result appears on the registered outputs in the next cycle and holds until the next start pulse.

Top module: `page_xlate_top`

## Requirements
- R1: After reset, `ram_sel`, `rom_sel`, `mem_wait` and `bank_sel` are all 0. The table holds the identity map (logical page p maps to frame p), and the ROM overlay is armed.
- R2: An access whose start pulse is seen at clock edge t shows its result from edge t+1 onward. `phys_addr[12:0]` equals the logical address bits 12:0. For a RAM access, `phys_addr[13]` equals bit 0 of the frame mapped to logical page `acc_addr[15:13]`. The outputs stay unchanged until the next start pulse.
- R3: For a RAM access, `bank_sel` is one-hot, with bit k set where k is frame bits 2:1. Frame bits 2:1 equal to 3 set `bank_sel[3]`, which is the top bank. `bank_sel` is 0 whenever `ram_sel` is 0.
- R4: A pulse on `map_we` stores `map_frame` in the entry `map_idx`. Later accesses to that page use the new frame, and the other entries are unchanged.
- R5: If an access start and a table write to the same entry fall on the same edge, that access uses the entry's previous frame. The next access uses the new frame.
- R6: While the overlay is armed, a read with `acc_addr[15:13]` equal to 0 gives `rom_sel`=1, `ram_sel`=0 and `bank_sel`=0.
- R7: A write to page 0, or a read from any other page, goes to RAM (`ram_sel`=1, `rom_sel`=0), even while the overlay is armed.
- R8: A ROM access raises `mem_wait` in the same cycle that `rom_sel` first appears. It holds `mem_wait` for exactly ROM_WAIT cycles (default 1). A RAM access never raises `mem_wait`.
- R9: A pulse on `rom_off` disarms the overlay. An access started on the same edge still sees the overlay armed. Afterwards, page-0 reads go to RAM through the table, and nothing but reset re-arms the overlay.
- R10: Asserting reset again re-arms the overlay and restores the identity map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_we | input | 1 | Write strobe for one table entry |
| map_idx | input | 3 | Logical page being remapped |
| map_frame | input | 3 | Physical frame to store |
| rom_off | input | 1 | Pulse that disarms the boot ROM overlay |
| acc_start | input | 1 | One-cycle pulse starting an access |
| acc_read | input | 1 | 1 for a read, 0 for a write |
| acc_addr | input | 16 | Logical address of the access |
| bank_sel | output | 4 | One-hot RAM bank select |
| phys_addr | output | 14 | Address inside the bank, with bit 13 taken from the table |
| ram_sel | output | 1 | Access goes to RAM |
| rom_sel | output | 1 | Access goes to the boot ROM |
| mem_wait | output | 1 | Extra-cycle request for the slow ROM |

## Verification
Two events can land on the same edge and need a defined outcome.

The first is a table write colliding with a lookup of the same entry. The bench drives `map_we` for page 2 together with an access start to address 0x4000. It expects the frame that page 2 held before the write, then repeats the access and expects the new frame.

The second is disarming the overlay while a page-0 read starts. The bench pulses `rom_off` on the same edge as that read and expects a ROM result with a one-cycle wait. The following page-0 read must resolve to RAM through the table.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;
  localparam int unsigned XL_ADDR_W   = 16;
  localparam int unsigned XL_PAGE_W   = 3;
  localparam int unsigned XL_FRAME_W  = 3;
  localparam int unsigned XL_ROM_WAIT = 1;

  // Where a translated access lands.
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_RAM  = 2'd1,
    TGT_ROM  = 2'd2
  } tgt_e;
endpackage

// File: rtl/page_map_table.sv
module page_map_table #(
  parameter int unsigned PAGE_W  = 3,
  parameter int unsigned FRAME_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [PAGE_W-1:0]  wr_idx,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic               rd_en,
  input  logic [PAGE_W-1:0]  rd_idx,
  output logic [FRAME_W-1:0] rd_frame
);
  localparam int unsigned DEPTH = 1 << PAGE_W;

  logic [FRAME_W-1:0] tbl [DEPTH];

  // Read-before-write: a lookup on the same edge as a write sees the old entry.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= FRAME_W'(i);
      rd_frame <= '0;
    end else begin
      if (wr_en) tbl[wr_idx] <= wr_frame;
      if (rd_en) rd_frame <= tbl[rd_idx];
    end
  end

  // R4/R5: no lookup means the registered frame holds
  assert_frame_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_frame));
endmodule

// File: rtl/boot_rom_gate.sv
module boot_rom_gate #(
  parameter int unsigned PAGE_W = 3,
  parameter int unsigned WAIT_N = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rom_off,
  input  logic              acc_start,
  input  logic              acc_read,
  input  logic [PAGE_W-1:0] acc_page,
  output logic              rom_hit_q,
  output logic              mem_wait
);
  localparam int unsigned CNT_W = $clog2(WAIT_N + 1);

  logic             rom_en;
  logic [CNT_W-1:0] wait_cnt;
  logic             hit;

  assign hit = rom_en && acc_read && (acc_page == '0);

  always_ff @(posedge clk) begin
    if (rst)          rom_en <= 1'b1;
    else if (rom_off) rom_en <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_hit_q <= 1'b0;
      wait_cnt  <= '0;
    end else if (acc_start) begin
      rom_hit_q <= hit;
      wait_cnt  <= hit ? CNT_W'(WAIT_N) : '0;
    end else if (wait_cnt != '0) begin
      wait_cnt  <= wait_cnt - 1'b1;
    end
  end

  assign mem_wait = (wait_cnt != '0);

  assert_overlay_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    !rom_en |=> !rom_en);
  assert_wait_only_rom_R8: assert property (@(posedge clk) disable iff (rst)
    mem_wait |-> rom_hit_q);
  assert_wait_starts_R8: assert property (@(posedge clk) disable iff (rst)
    (acc_start && hit) |=> mem_wait);
endmodule

// File: rtl/bank_decode.sv
module bank_decode #(
  parameter int unsigned BANK_W = 2
) (
  input  logic                     en,
  input  logic [BANK_W-1:0]        idx,
  output logic [(1<<BANK_W)-1:0]   onehot
);
  for (genvar k = 0; k < (1 << BANK_W); k++) begin : g_bank
    assign onehot[k] = en && (idx == BANK_W'(k));
  end
endmodule

// File: rtl/page_xlate_top.sv
module page_xlate_top
  import page_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W   = XL_ADDR_W,
  parameter int unsigned PAGE_W   = XL_PAGE_W,
  parameter int unsigned FRAME_W  = XL_FRAME_W,
  parameter int unsigned ROM_WAIT = XL_ROM_WAIT
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          map_we,
  input  logic [PAGE_W-1:0]             map_idx,
  input  logic [FRAME_W-1:0]            map_frame,
  input  logic                          rom_off,
  input  logic                          acc_start,
  input  logic                          acc_read,
  input  logic [ADDR_W-1:0]             acc_addr,
  output logic [(1<<(FRAME_W-1))-1:0]   bank_sel,
  output logic [ADDR_W-PAGE_W:0]        phys_addr,
  output logic                          ram_sel,
  output logic                          rom_sel,
  output logic                          mem_wait
);
  localparam int unsigned OFF_W  = ADDR_W - PAGE_W;
  localparam int unsigned BANK_W = FRAME_W - 1;

  logic [PAGE_W-1:0]  acc_page;
  logic [FRAME_W-1:0] frame_q;
  logic [OFF_W-1:0]   off_q;
  logic               seen_q;
  logic               rom_hit_q;
  tgt_e               tgt;

  assign acc_page = acc_addr[ADDR_W-1 -: PAGE_W];

  page_map_table #(.PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) map_i (
    .clk(clk), .rst(rst),
    .wr_en(map_we), .wr_idx(map_idx), .wr_frame(map_frame),
    .rd_en(acc_start), .rd_idx(acc_page), .rd_frame(frame_q)
  );

  boot_rom_gate #(.PAGE_W(PAGE_W), .WAIT_N(ROM_WAIT)) rom_i (
    .clk(clk), .rst(rst), .rom_off(rom_off),
    .acc_start(acc_start), .acc_read(acc_read), .acc_page(acc_page),
    .rom_hit_q(rom_hit_q), .mem_wait(mem_wait)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q  <= '0;
      seen_q <= 1'b0;
    end else if (acc_start) begin
      off_q  <= acc_addr[OFF_W-1:0];
      seen_q <= 1'b1;
    end
  end

  always_comb begin
    if (!seen_q)        tgt = TGT_NONE;
    else if (rom_hit_q) tgt = TGT_ROM;
    else                tgt = TGT_RAM;
  end

  assign ram_sel   = (tgt == TGT_RAM);
  assign rom_sel   = (tgt == TGT_ROM);
  assign phys_addr = {frame_q[0], off_q};

  bank_decode #(.BANK_W(BANK_W)) dec_i (
    .en(ram_sel), .idx(frame_q[FRAME_W-1:1]), .onehot(bank_sel)
  );

  assert_offset_pass_R2: assert property (@(posedge clk) disable iff (rst)
    acc_start |=> phys_addr[OFF_W-1:0] == $past(acc_addr[OFF_W-1:0]));
  assert_result_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !acc_start |=> $stable(phys_addr) && $stable(bank_sel) && $stable(rom_sel));
  assert_bank_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    ram_sel |-> $countones(bank_sel) == 1);
  assert_bank_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !ram_sel |-> bank_sel == '0);
  assert_target_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(ram_sel && rom_sel));
  assert_write_to_ram_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_start && !acc_read) |=> ram_sel);
endmodule

// File: tb/page_xlate_tb.sv
module page_xlate_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        map_we;
  logic [2:0]  map_idx;
  logic [2:0]  map_frame;
  logic        rom_off;
  logic        acc_start;
  logic        acc_read;
  logic [15:0] acc_addr;
  logic [3:0]  bank_sel;
  logic [13:0] phys_addr;
  logic        ram_sel;
  logic        rom_sel;
  logic        mem_wait;

  int n_chk  = 0;
  int n_fail = 0;
  logic [2:0] model_map [8];
  logic       model_rom;

  always #10 clk = ~clk;

  page_xlate_top dut_i (
    .clk(clk), .rst(rst), .map_we(map_we), .map_idx(map_idx),
    .map_frame(map_frame), .rom_off(rom_off), .acc_start(acc_start),
    .acc_read(acc_read), .acc_addr(acc_addr), .bank_sel(bank_sel),
    .phys_addr(phys_addr), .ram_sel(ram_sel), .rom_sel(rom_sel),
    .mem_wait(mem_wait)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) model_map[i] = 3'(i);
    model_rom = 1'b1;
  endtask

  task automatic do_reset(input string req);
    @(negedge clk);
    rst = 1'b1; map_we = 0; rom_off = 0; acc_start = 0; acc_read = 0;
    acc_addr = '0; map_idx = '0; map_frame = '0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    check({req, " ram_sel idle"}, 32'(ram_sel), 0);
    check({req, " rom_sel idle"}, 32'(rom_sel), 0);
    check({req, " mem_wait idle"}, 32'(mem_wait), 0);
    check({req, " bank_sel idle"}, 32'(bank_sel), 0);
  endtask

  // Checks both result cycles of one access against the model.
  task automatic check_result(input string req, input logic [15:0] a,
                              input logic is_rom, input logic [2:0] f);
    check({req, " rom_sel"}, 32'(rom_sel), 32'(is_rom));
    check({req, " ram_sel"}, 32'(ram_sel), 32'(!is_rom));
    check({req, " bank_sel"}, 32'(bank_sel), is_rom ? 0 : 32'(4'b1 << f[2:1]));
    if (!is_rom) check({req, " phys_addr"}, 32'(phys_addr), 32'({f[0], a[12:0]}));
    check({req, " mem_wait first"}, 32'(mem_wait), 32'(is_rom));
    @(negedge clk);
    check({req, " mem_wait released"}, 32'(mem_wait), 0);
    check({req, " rom_sel held"}, 32'(rom_sel), 32'(is_rom));
  endtask

  task automatic do_access(input string req, input logic [15:0] a, input logic rd);
    logic is_rom;
    logic [2:0] f;
    is_rom = model_rom && rd && (a[15:13] == 3'd0);
    f = model_map[a[15:13]];
    acc_start = 1'b1; acc_read = rd; acc_addr = a;
    @(negedge clk);
    acc_start = 1'b0;
    check_result(req, a, is_rom, f);
  endtask

  task automatic wr_map(input logic [2:0] idx, input logic [2:0] fr);
    map_we = 1'b1; map_idx = idx; map_frame = fr;
    @(negedge clk);
    map_we = 1'b0;
    model_map[idx] = fr;
  endtask

  task automatic t_identity();
    for (int p = 1; p < 8; p++) do_access("R1 identity R3", 16'(p << 13) | 16'h0abc, 1'b1);
    do_access("R2 page7 write", 16'hffff, 1'b0);
  endtask

  task automatic t_rom_overlay();
    do_access("R6 R8 rom read", 16'h0123, 1'b1);
    do_access("R7 page0 write", 16'h0100, 1'b0);
    do_access("R7 page1 read", 16'h2000, 1'b1);
  endtask

  task automatic t_map_write();
    wr_map(3'd5, 3'd6);
    do_access("R4 remapped page5 R3", 16'ha555, 1'b1);
    do_access("R4 page4 untouched", 16'h8001, 1'b1);
    for (int p = 0; p < 8; p++) wr_map(3'(p), 3'(7 - p));
    for (int p = 1; p < 8; p++) do_access("R4 reversed map R2", 16'(p << 13) | 16'(p * 3), 1'b0);
  endtask

  task automatic t_collision();
    logic [2:0] old_f;
    old_f = model_map[2];
    map_we = 1'b1; map_idx = 3'd2; map_frame = 3'd1;
    acc_start = 1'b1; acc_read = 1'b1; acc_addr = 16'h4000;
    @(negedge clk);
    map_we = 1'b0; acc_start = 1'b0;
    model_map[2] = 3'd1;
    check_result("R5 collision old frame", 16'h4000, 1'b0, old_f);
    do_access("R5 after collision new frame", 16'h4000, 1'b1);
  endtask

  task automatic t_rom_off();
    rom_off = 1'b1;
    acc_start = 1'b1; acc_read = 1'b1; acc_addr = 16'h0010;
    @(negedge clk);
    rom_off = 1'b0; acc_start = 1'b0;
    check_result("R9 same-edge disarm still rom", 16'h0010, 1'b1, model_map[0]);
    model_rom = 1'b0;
    do_access("R9 page0 read to ram", 16'h0010, 1'b1);
    wr_map(3'd0, 3'd6);
    do_access("R9 page0 read via map", 16'h1fff, 1'b1);
  endtask

  task automatic t_rereset();
    do_reset("R10 reset");
    do_access("R10 overlay rearmed", 16'h0042, 1'b1);
    do_access("R10 page0 write identity", 16'h0042, 1'b0);
    do_access("R10 page5 identity", 16'ha000, 1'b1);
  endtask

  initial begin
    do_reset("R1 reset");
    t_identity();
    t_rom_overlay();
    t_map_write();
    t_collision();
    t_rom_off();
    t_rereset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule